// File: doc/BRIEF.md
# Dual-Retire Scoreboard with Reorder Buffer

This block tracks every instruction that has left the issue stage and has not yet retired. It keeps a small circular buffer of eight entries. An accepted issue takes the entry at the tail and records which register the instruction will write. Functional units return results in any order and name the entry they belong to. The issue stage asks about the two source registers of its next instruction. For each one the block reports whether an in-flight instruction will write it, whether that result is already available, and the result itself.

Write-after-write conflicts are removed without a rename table. Every architectural register address is one bit wider. A version table holds one bit per register, and each instruction that writes a register flips that bit, so back-to-back writers of one register get alternating physical addresses. Source lookups always use the current version. A second table holds the version of the last write that retired. A flush restores the first table from the second.

The oldest entries appear on a two-slot commit port, which retires zero, one or two instructions per cycle, always in program order.

Top module: `sb_rob_scoreboard`

## Requirements
- R1: After reset or after a cycle with `flush_i` high, no commit slot is valid, `iss_ready_o` is 1 and `iss_idx_o` is 0; a flush drops every in-flight entry.
- R2: An issue is accepted when `iss_valid_i` and `iss_ready_o` are both high. It takes the entry numbered `iss_idx_o`, and the next accepted issue gets the following index, modulo 8. With 8 entries in flight `iss_ready_o` is 0 and an issue request changes nothing.
- R3: A physical register address is {version bit, architectural address}, so the version sits in bit 5. Sources map to {current version, rs}. A writing issue to rd other than 0 gets {inverted current version, rd} and flips that register's version. The versions of all registers start at 0 after reset.
- R4: A source "hits" when an in-flight writing entry has the same physical destination. Source register 0 never hits. `iss_hazard_o` is high when a source hits and its selected writer has no result yet.
- R5: When several in-flight entries write the same physical register, the youngest one is selected, and its result is forwarded on `rsN_data_o` with `rsN_ready_o` high.
- R6: A writeback stores data into the named entry and marks it finished. The result becomes visible on the forwarding and commit outputs from the next cycle. Writebacks to empty entries are ignored.
- R7: Commit slot 0 shows the oldest entry and is valid when that entry is finished. Slot 1 shows the next-oldest entry and is valid only when both entries are finished.
- R8: `cm_ack_i[0]` on a valid slot 0 retires one entry. Adding `cm_ack_i[1]` on a valid slot 1 retires two. `cm_ack_i[1]` without `cm_ack_i[0]` is ignored.
- R9: In a cycle with both an issue and a commit, the occupancy changes by the number issued minus the number retired.
- R10: A flush reloads each register's current version from its committed version. Retirements in the flush cycle are discarded.
- R11: Each retiring writer sets the committed version of its register to bit 5 of its physical destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all in-flight entries |
| iss_valid_i | input | 1 | Issue request |
| iss_ready_o | output | 1 | A free entry exists |
| iss_idx_o | output | 3 | Entry index an issue would take |
| iss_rs1_i | input | 5 | Source 1 architectural register |
| iss_rs2_i | input | 5 | Source 2 architectural register |
| iss_rd_i | input | 5 | Destination architectural register |
| iss_rd_we_i | input | 1 | Instruction writes rd |
| iss_rs1_phys_o | output | 6 | Renamed source 1 |
| iss_rs2_phys_o | output | 6 | Renamed source 2 |
| iss_rd_phys_o | output | 6 | Renamed destination |
| rs1_hit_o | output | 1 | Source 1 has an in-flight writer |
| rs1_ready_o | output | 1 | Source 1 result available |
| rs1_data_o | output | 64 | Source 1 forwarded result |
| rs2_hit_o | output | 1 | Source 2 has an in-flight writer |
| rs2_ready_o | output | 1 | Source 2 result available |
| rs2_data_o | output | 64 | Source 2 forwarded result |
| iss_hazard_o | output | 1 | A source waits on an unfinished writer |
| wb_valid_i | input | 2 | Writeback strobes, one per port |
| wb_idx_i | input | 2x3 | Writeback entry indices |
| wb_data_i | input | 2x64 | Writeback results |
| cm_valid_o | output | 2 | Commit slot valid |
| cm_we_o | output | 2 | Commit slot writes a register |
| cm_rd_phys_o | output | 2x6 | Commit slot physical destination |
| cm_data_o | output | 2x64 | Commit slot result |
| cm_ack_i | input | 2 | Retire commit slots |

## Verification
Two operations can land on the occupancy counter in one cycle: an issue at the tail and a retirement at the head. The bench fills the buffer and then acknowledges two commits while requesting an issue, which must be refused because the full condition is a registered state. It then acknowledges one commit and issues at the same edge. The result is judged by how many further issues are accepted before `iss_ready_o` drops, and by the wrapped tail index each one reports. Writeback and commit also overlap: the bench finishes an older entry while a younger one is already finished and checks that both slots only open together, in order.

// File: rtl/sb_pkg.sv
package sb_pkg;

  localparam int NR_CM = 2;

  // number of entries retired given slot validity and acknowledges
  function automatic logic [1:0] retire_count(input logic [1:0] slot_v,
                                              input logic [1:0] ack,
                                              input logic       flush);
    logic [1:0] n;
    n = 2'd0;
    if (!flush && slot_v[0] && ack[0]) begin
      n = (slot_v[1] && ack[1]) ? 2'd2 : 2'd1;
    end
    return n;
  endfunction

  // occupancy after one cycle of issue and retirement
  function automatic int next_occupancy(input int occ, input logic fire, input int retired);
    return occ + int'(fire) - retired;
  endfunction

endpackage

// File: rtl/sb_rename.sv
module sb_rename #(
  parameter int ARCH_REGS = 32,
  parameter int ARCH_W    = 5,
  parameter int PHYS_W    = ARCH_W + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        flush_i,
  input  logic                        iss_fire_i,
  input  logic                        iss_writer_i,
  input  logic [ARCH_W-1:0]           iss_rd_i,
  input  logic [ARCH_W-1:0]           iss_rs1_i,
  input  logic [ARCH_W-1:0]           iss_rs2_i,
  output logic [PHYS_W-1:0]           rs1_phys_o,
  output logic [PHYS_W-1:0]           rs2_phys_o,
  output logic [PHYS_W-1:0]           rd_phys_o,
  input  logic [1:0]                  cm_en_i,
  input  logic [1:0][PHYS_W-1:0]      cm_rd_phys_i
);

  logic [ARCH_REGS-1:0] spec_ver_q;
  logic [ARCH_REGS-1:0] com_ver_q;

  assign rs1_phys_o = {spec_ver_q[iss_rs1_i], iss_rs1_i};
  assign rs2_phys_o = {spec_ver_q[iss_rs2_i], iss_rs2_i};
  assign rd_phys_o  = iss_writer_i ? {~spec_ver_q[iss_rd_i], iss_rd_i} : {1'b0, iss_rd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spec_ver_q <= '0;
      com_ver_q  <= '0;
    end else begin
      if (flush_i) begin
        spec_ver_q <= com_ver_q;
      end else if (iss_fire_i && iss_writer_i) begin
        spec_ver_q[iss_rd_i] <= ~spec_ver_q[iss_rd_i];
      end
      for (int k = 0; k < 2; k++) begin
        if (cm_en_i[k]) begin
          com_ver_q[cm_rd_phys_i[k][ARCH_W-1:0]] <= cm_rd_phys_i[k][ARCH_W];
        end
      end
    end
  end

endmodule

// File: rtl/sb_src_lookup.sv
module sb_src_lookup #(
  parameter int NR_ENTRIES = 8,
  parameter int IDX_W      = 3,
  parameter int ARCH_W     = 5,
  parameter int PHYS_W     = ARCH_W + 1,
  parameter int DATA_W     = 64
) (
  input  logic [IDX_W-1:0]                   head_i,
  input  logic [NR_ENTRIES-1:0]              valid_i,
  input  logic [NR_ENTRIES-1:0]              done_i,
  input  logic [NR_ENTRIES-1:0]              writer_i,
  input  logic [NR_ENTRIES-1:0][PHYS_W-1:0]  dest_i,
  input  logic [NR_ENTRIES-1:0][DATA_W-1:0]  data_i,
  input  logic [PHYS_W-1:0]                  src_phys_i,
  output logic                               hit_o,
  output logic                               ready_o,
  output logic [DATA_W-1:0]                  data_o
);

  logic             src_is_zero;
  logic             found;
  logic [IDX_W-1:0] sel_idx;
  logic [IDX_W-1:0] scan_idx;

  assign src_is_zero = (src_phys_i[ARCH_W-1:0] == '0);

  // walk from oldest to youngest; the last match is the youngest writer
  always_comb begin
    found    = 1'b0;
    sel_idx  = '0;
    scan_idx = '0;
    for (int a = 0; a < NR_ENTRIES; a++) begin
      scan_idx = head_i + IDX_W'(a);
      if (valid_i[scan_idx] && writer_i[scan_idx] && !src_is_zero &&
          dest_i[scan_idx] == src_phys_i) begin
        found   = 1'b1;
        sel_idx = scan_idx;
      end
    end
  end

  assign hit_o   = found;
  assign ready_o = found && done_i[sel_idx];
  assign data_o  = ready_o ? data_i[sel_idx] : '0;

endmodule

// File: rtl/sb_commit_sel.sv
module sb_commit_sel #(
  parameter int NR_ENTRIES = 8,
  parameter int IDX_W      = 3,
  parameter int PHYS_W     = 6,
  parameter int DATA_W     = 64
) (
  input  logic [IDX_W-1:0]                   head_i,
  input  logic [NR_ENTRIES-1:0]              valid_i,
  input  logic [NR_ENTRIES-1:0]              done_i,
  input  logic [NR_ENTRIES-1:0]              writer_i,
  input  logic [NR_ENTRIES-1:0][PHYS_W-1:0]  dest_i,
  input  logic [NR_ENTRIES-1:0][DATA_W-1:0]  data_i,
  input  logic                               flush_i,
  input  logic [1:0]                         ack_i,
  output logic [1:0]                         cm_valid_o,
  output logic [1:0]                         cm_we_o,
  output logic [1:0][PHYS_W-1:0]             cm_rd_phys_o,
  output logic [1:0][DATA_W-1:0]             cm_data_o,
  output logic [1:0]                         retire_cnt_o,
  output logic [1:0]                         retire_mask_o
);

  logic [1:0] entry_fin;

  for (genvar k = 0; k < sb_pkg::NR_CM; k++) begin : g_slot
    logic [IDX_W-1:0] idx;
    assign idx             = head_i + IDX_W'(k);
    assign entry_fin[k]    = valid_i[idx] && done_i[idx];
    assign cm_we_o[k]      = writer_i[idx];
    assign cm_rd_phys_o[k] = dest_i[idx];
    assign cm_data_o[k]    = data_i[idx];
  end

  assign cm_valid_o[0] = entry_fin[0];
  assign cm_valid_o[1] = entry_fin[0] && entry_fin[1];

  assign retire_cnt_o     = sb_pkg::retire_count(cm_valid_o, ack_i, flush_i);
  assign retire_mask_o[0] = (retire_cnt_o != 2'd0);
  assign retire_mask_o[1] = (retire_cnt_o == 2'd2);

endmodule

// File: rtl/sb_rob_scoreboard.sv
module sb_rob_scoreboard #(
  parameter int NR_ENTRIES = 8,
  parameter int ARCH_REGS  = 32,
  parameter int DATA_W     = 64,
  parameter int NR_WB      = 2,
  localparam int IDX_W     = $clog2(NR_ENTRIES),
  localparam int ARCH_W    = $clog2(ARCH_REGS),
  localparam int PHYS_W    = ARCH_W + 1,
  localparam int CNT_W     = $clog2(NR_ENTRIES + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           flush_i,
  input  logic                           iss_valid_i,
  output logic                           iss_ready_o,
  output logic [IDX_W-1:0]               iss_idx_o,
  input  logic [ARCH_W-1:0]              iss_rs1_i,
  input  logic [ARCH_W-1:0]              iss_rs2_i,
  input  logic [ARCH_W-1:0]              iss_rd_i,
  input  logic                           iss_rd_we_i,
  output logic [PHYS_W-1:0]              iss_rs1_phys_o,
  output logic [PHYS_W-1:0]              iss_rs2_phys_o,
  output logic [PHYS_W-1:0]              iss_rd_phys_o,
  output logic                           rs1_hit_o,
  output logic                           rs1_ready_o,
  output logic [DATA_W-1:0]              rs1_data_o,
  output logic                           rs2_hit_o,
  output logic                           rs2_ready_o,
  output logic [DATA_W-1:0]              rs2_data_o,
  output logic                           iss_hazard_o,
  input  logic [NR_WB-1:0]               wb_valid_i,
  input  logic [NR_WB-1:0][IDX_W-1:0]    wb_idx_i,
  input  logic [NR_WB-1:0][DATA_W-1:0]   wb_data_i,
  output logic [1:0]                     cm_valid_o,
  output logic [1:0]                     cm_we_o,
  output logic [1:0][PHYS_W-1:0]         cm_rd_phys_o,
  output logic [1:0][DATA_W-1:0]         cm_data_o,
  input  logic [1:0]                     cm_ack_i
);

  // entry storage
  logic [NR_ENTRIES-1:0]             valid_q;
  logic [NR_ENTRIES-1:0]             done_q;
  logic [NR_ENTRIES-1:0]             writer_q;
  logic [NR_ENTRIES-1:0][PHYS_W-1:0] dest_q;
  logic [NR_ENTRIES-1:0][DATA_W-1:0] data_q;

  logic [IDX_W-1:0] head_q;
  logic [IDX_W-1:0] tail_q;
  logic [CNT_W-1:0] occ_q;

  // named internal events
  logic             iss_fire;
  logic             iss_writer;
  logic [1:0]       retire_cnt;
  logic [1:0]       retire_mask;
  logic [1:0]       cm_rename_en;

  assign iss_ready_o = (occ_q != CNT_W'(NR_ENTRIES));
  assign iss_idx_o   = tail_q;
  assign iss_fire    = iss_valid_i && iss_ready_o && !flush_i;
  assign iss_writer  = iss_rd_we_i && (iss_rd_i != '0);

  sb_rename #(
    .ARCH_REGS (ARCH_REGS),
    .ARCH_W    (ARCH_W),
    .PHYS_W    (PHYS_W)
  ) u_rename (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .iss_fire_i   (iss_fire),
    .iss_writer_i (iss_writer),
    .iss_rd_i     (iss_rd_i),
    .iss_rs1_i    (iss_rs1_i),
    .iss_rs2_i    (iss_rs2_i),
    .rs1_phys_o   (iss_rs1_phys_o),
    .rs2_phys_o   (iss_rs2_phys_o),
    .rd_phys_o    (iss_rd_phys_o),
    .cm_en_i      (cm_rename_en),
    .cm_rd_phys_i (cm_rd_phys_o)
  );

  sb_src_lookup #(
    .NR_ENTRIES (NR_ENTRIES),
    .IDX_W      (IDX_W),
    .ARCH_W     (ARCH_W),
    .PHYS_W     (PHYS_W),
    .DATA_W     (DATA_W)
  ) u_lookup_rs1 (
    .head_i     (head_q),
    .valid_i    (valid_q),
    .done_i     (done_q),
    .writer_i   (writer_q),
    .dest_i     (dest_q),
    .data_i     (data_q),
    .src_phys_i (iss_rs1_phys_o),
    .hit_o      (rs1_hit_o),
    .ready_o    (rs1_ready_o),
    .data_o     (rs1_data_o)
  );

  sb_src_lookup #(
    .NR_ENTRIES (NR_ENTRIES),
    .IDX_W      (IDX_W),
    .ARCH_W     (ARCH_W),
    .PHYS_W     (PHYS_W),
    .DATA_W     (DATA_W)
  ) u_lookup_rs2 (
    .head_i     (head_q),
    .valid_i    (valid_q),
    .done_i     (done_q),
    .writer_i   (writer_q),
    .dest_i     (dest_q),
    .data_i     (data_q),
    .src_phys_i (iss_rs2_phys_o),
    .hit_o      (rs2_hit_o),
    .ready_o    (rs2_ready_o),
    .data_o     (rs2_data_o)
  );

  assign iss_hazard_o = (rs1_hit_o && !rs1_ready_o) || (rs2_hit_o && !rs2_ready_o);

  sb_commit_sel #(
    .NR_ENTRIES (NR_ENTRIES),
    .IDX_W      (IDX_W),
    .PHYS_W     (PHYS_W),
    .DATA_W     (DATA_W)
  ) u_commit (
    .head_i        (head_q),
    .valid_i       (valid_q),
    .done_i        (done_q),
    .writer_i      (writer_q),
    .dest_i        (dest_q),
    .data_i        (data_q),
    .flush_i       (flush_i),
    .ack_i         (cm_ack_i),
    .cm_valid_o    (cm_valid_o),
    .cm_we_o       (cm_we_o),
    .cm_rd_phys_o  (cm_rd_phys_o),
    .cm_data_o     (cm_data_o),
    .retire_cnt_o  (retire_cnt),
    .retire_mask_o (retire_mask)
  );

  assign cm_rename_en = retire_mask & cm_we_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      done_q   <= '0;
      writer_q <= '0;
      dest_q   <= '0;
      data_q   <= '0;
      head_q   <= '0;
      tail_q   <= '0;
      occ_q    <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
      done_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      occ_q   <= '0;
    end else begin
      for (int w = 0; w < NR_WB; w++) begin
        if (wb_valid_i[w] && valid_q[wb_idx_i[w]]) begin
          done_q[wb_idx_i[w]] <= 1'b1;
          data_q[wb_idx_i[w]] <= wb_data_i[w];
        end
      end
      for (int k = 0; k < 2; k++) begin
        if (retire_mask[k]) begin
          valid_q[head_q + IDX_W'(k)] <= 1'b0;
        end
      end
      if (iss_fire) begin
        valid_q[tail_q]  <= 1'b1;
        done_q[tail_q]   <= 1'b0;
        writer_q[tail_q] <= iss_writer;
        dest_q[tail_q]   <= iss_rd_phys_o;
      end
      head_q <= head_q + IDX_W'(retire_cnt);
      tail_q <= tail_q + IDX_W'(iss_fire);
      occ_q  <= CNT_W'(sb_pkg::next_occupancy(int'(occ_q), iss_fire, int'(retire_cnt)));
    end
  end

endmodule

// File: rtl/sb_rob_checker.sv
module sb_rob_checker #(
  parameter int NR_ENTRIES = 8,
  parameter int IDX_W      = 3,
  parameter int CNT_W      = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             iss_ready_o,
  input logic             iss_hazard_o,
  input logic             rs1_hit_o,
  input logic             rs2_hit_o,
  input logic [1:0]       cm_valid_o,
  input logic [1:0]       cm_ack_i,
  input logic             iss_fire,
  input logic [1:0]       retire_cnt,
  input logic [CNT_W-1:0] occ_q,
  input logic [IDX_W-1:0] head_q
);

  // R9: occupancy follows issue minus retire
  a_r9_occupancy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> occ_q == CNT_W'($past(occ_q) + CNT_W'($past(iss_fire)) - CNT_W'($past(retire_cnt))));

  // R7: slot 1 never opens alone
  a_r7_slot_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_valid_o[1] |-> cm_valid_o[0]);

  // R8: a lone second acknowledge does not move the head
  a_r8_lone_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && cm_ack_i == 2'b10) |=> head_q == $past(head_q));

  // R8: never retire more than the valid slots
  a_r8_retire_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_cnt <= 2'($countones(cm_valid_o)));

  // R1, R10: flush leaves an empty buffer
  a_r10_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cm_valid_o == 2'b00 && iss_ready_o && occ_q == '0));

  // R4: a hazard needs an in-flight writer
  a_r4_hazard_has_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_hazard_o |-> (rs1_hit_o || rs2_hit_o));

  // R2: nothing enters a full buffer
  a_r2_no_fire_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == CNT_W'(NR_ENTRIES)) |-> !iss_fire);

endmodule

bind sb_rob_scoreboard sb_rob_checker #(
  .NR_ENTRIES (NR_ENTRIES),
  .IDX_W      (IDX_W),
  .CNT_W      (CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .iss_ready_o  (iss_ready_o),
  .iss_hazard_o (iss_hazard_o),
  .rs1_hit_o    (rs1_hit_o),
  .rs2_hit_o    (rs2_hit_o),
  .cm_valid_o   (cm_valid_o),
  .cm_ack_i     (cm_ack_i),
  .iss_fire     (iss_fire),
  .retire_cnt   (retire_cnt),
  .occ_q        (occ_q),
  .head_q       (head_q)
);

// File: tb/sb_rob_scoreboard_tb.sv
module sb_rob_scoreboard_tb;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             flush;
  logic             iss_valid;
  logic             iss_ready;
  logic [2:0]       iss_idx;
  logic [4:0]       rs1, rs2, rd;
  logic             rd_we;
  logic [5:0]       rs1_phys, rs2_phys, rd_phys;
  logic             rs1_hit, rs1_ready, rs2_hit, rs2_ready, hazard;
  logic [63:0]      rs1_data, rs2_data;
  logic [1:0]       wb_valid;
  logic [1:0][2:0]  wb_idx;
  logic [1:0][63:0] wb_data;
  logic [1:0]       cm_valid, cm_we, cm_ack;
  logic [1:0][5:0]  cm_phys;
  logic [1:0][63:0] cm_data;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sb_rob_scoreboard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .iss_valid_i(iss_valid), .iss_ready_o(iss_ready), .iss_idx_o(iss_idx),
    .iss_rs1_i(rs1), .iss_rs2_i(rs2), .iss_rd_i(rd), .iss_rd_we_i(rd_we),
    .iss_rs1_phys_o(rs1_phys), .iss_rs2_phys_o(rs2_phys), .iss_rd_phys_o(rd_phys),
    .rs1_hit_o(rs1_hit), .rs1_ready_o(rs1_ready), .rs1_data_o(rs1_data),
    .rs2_hit_o(rs2_hit), .rs2_ready_o(rs2_ready), .rs2_data_o(rs2_data),
    .iss_hazard_o(hazard),
    .wb_valid_i(wb_valid), .wb_idx_i(wb_idx), .wb_data_i(wb_data),
    .cm_valid_o(cm_valid), .cm_we_o(cm_we), .cm_rd_phys_o(cm_phys),
    .cm_data_o(cm_data), .cm_ack_i(cm_ack)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic issue(input logic [4:0] d, input logic we, input logic [2:0] exp_idx,
                       input logic [5:0] exp_phys, input bit chk_phys);
    iss_valid = 1'b1; rd = d; rd_we = we;
    #1;
    chk("R2", "ready before issue", iss_ready, 1'b1);
    chk("R2", "issue index", iss_idx, exp_idx);
    if (chk_phys) chk("R3", "renamed destination", rd_phys, exp_phys);
    tick();
    iss_valid = 1'b0; rd_we = 1'b0;
  endtask

  task automatic writeback(input logic [1:0] v, input logic [2:0] i0, input logic [63:0] d0,
                           input logic [2:0] i1, input logic [63:0] d1);
    wb_valid = v; wb_idx[0] = i0; wb_data[0] = d0; wb_idx[1] = i1; wb_data[1] = d1;
    tick();
    wb_valid = 2'b00;
  endtask

  task automatic ack(input logic [1:0] a);
    cm_ack = a;
    tick();
    cm_ack = 2'b00;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    tick();
    flush = 1'b0;
    #1;
  endtask

  task automatic test_reset();
    rs1 = 5'd5; rs2 = 5'd6;
    #1;
    chk("R1", "ready after reset", iss_ready, 1'b1);
    chk("R1", "commit slots after reset", cm_valid, 2'b00);
    chk("R1", "tail after reset", iss_idx, 3'd0);
    chk("R3", "initial version of x5", rs1_phys, 6'd5);
    chk("R4", "no hit when empty", rs1_hit, 1'b0);
  endtask

  task automatic test_rename();
    issue(5'd5, 1'b1, 3'd0, 6'd37, 1);
    issue(5'd6, 1'b1, 3'd1, 6'd38, 1);
    issue(5'd5, 1'b1, 3'd2, 6'd5,  1);
    issue(5'd5, 1'b1, 3'd3, 6'd37, 1);
    rs1 = 5'd5; rs2 = 5'd6;
    #1;
    chk("R3", "source x5 follows latest version", rs1_phys, 6'd37);
    chk("R3", "source x6 version", rs2_phys, 6'd38);
    chk("R4", "rs1 hit on pending writer", rs1_hit, 1'b1);
    chk("R4", "hazard on pending writer", hazard, 1'b1);
  endtask

  task automatic test_youngest();
    writeback(2'b01, 3'd0, 64'h11, 3'd0, 64'h0);
    #1;
    chk("R5", "youngest writer of 37 still pending", rs1_ready, 1'b0);
    chk("R5", "rs1 hit with older writer done", rs1_hit, 1'b1);
    writeback(2'b11, 3'd3, 64'h33, 3'd2, 64'h22);
    #1;
    chk("R6", "result visible after writeback", rs1_ready, 1'b1);
    chk("R5", "youngest writer data forwarded", rs1_data, 64'h33);
    chk("R4", "hazard remains on x6", hazard, 1'b1);
    rs2 = 5'd0;
    #1;
    chk("R4", "register 0 never hits", rs2_hit, 1'b0);
    chk("R4", "no hazard once x0 replaces x6", hazard, 1'b0);
  endtask

  task automatic test_commit();
    #1;
    chk("R7", "only oldest finished slot valid", cm_valid, 2'b01);
    chk("R7", "slot0 destination", cm_phys[0], 6'd37);
    chk("R7", "slot0 data", cm_data[0], 64'h11);
    ack(2'b01);
    #1;
    chk("R7", "in order: finished younger waits", cm_valid, 2'b00);
    writeback(2'b01, 3'd1, 64'h66, 3'd0, 64'h0);
    #1;
    chk("R7", "both slots open", cm_valid, 2'b11);
    chk("R7", "slot0 destination x6", cm_phys[0], 6'd38);
    chk("R7", "slot1 destination x5 v0", cm_phys[1], 6'd5);
    chk("R7", "slot1 data", cm_data[1], 64'h22);
    ack(2'b11);
    #1;
    chk("R8", "two retired, next oldest shown", cm_valid, 2'b01);
    chk("R8", "slot0 now entry 3", cm_data[0], 64'h33);
    ack(2'b10);
    #1;
    chk("R8", "lone second ack ignored", cm_valid, 2'b01);
    chk("R8", "lone second ack keeps entry", cm_phys[0], 6'd37);
    ack(2'b01);
    #1;
    chk("R8", "buffer drained", cm_valid, 2'b00);
    rs1 = 5'd5;
    #1;
    chk("R4", "no hit after retirement", rs1_hit, 1'b0);
  endtask

  task automatic test_full();
    do_flush();
    chk("R1", "tail after flush", iss_idx, 3'd0);
    for (int i = 0; i < 8; i++) issue(5'd9, 1'b1, 3'(i), 6'd0, 0);
    #1;
    chk("R2", "full refuses issue", iss_ready, 1'b0);
    iss_valid = 1'b1; rd = 5'd9; rd_we = 1'b1;
    tick();
    iss_valid = 1'b0;
    #1;
    chk("R2", "refused issue leaves index", iss_idx, 3'd0);
    writeback(2'b11, 3'd0, 64'hA0, 3'd1, 64'hA1);
    #1;
    chk("R7", "two oldest finished", cm_valid, 2'b11);
    chk("R3", "entry0 dest version 1", cm_phys[0], 6'd41);
    chk("R3", "entry1 dest version 0", cm_phys[1], 6'd9);
    cm_ack = 2'b11; iss_valid = 1'b1;
    tick();
    cm_ack = 2'b00; iss_valid = 1'b0;
    #1;
    chk("R9", "two retired while full, issue refused", iss_ready, 1'b1);
    chk("R9", "tail unchanged by refused issue", iss_idx, 3'd0);
    writeback(2'b01, 3'd2, 64'hA2, 3'd0, 64'h0);
    cm_ack = 2'b01; iss_valid = 1'b1; rd = 5'd9; rd_we = 1'b1;
    #1;
    chk("R9", "issue index during commit", iss_idx, 3'd0);
    tick();
    cm_ack = 2'b00; iss_valid = 1'b0;
    issue(5'd9, 1'b1, 3'd1, 6'd0, 0);
    #1;
    chk("R9", "seven in flight leaves room", iss_ready, 1'b1);
    issue(5'd9, 1'b1, 3'd2, 6'd0, 0);
    #1;
    chk("R9", "eight in flight after mixed cycle", iss_ready, 1'b0);
  endtask

  task automatic test_flush();
    do_flush();
    rs1 = 5'd9; rs2 = 5'd5;
    #1;
    chk("R1", "ready after flush", iss_ready, 1'b1);
    chk("R1", "no commit after flush", cm_valid, 2'b00);
    chk("R1", "index after flush", iss_idx, 3'd0);
    chk("R10", "no hit after flush", rs1_hit, 1'b0);
    chk("R11", "x9 restored to committed version", rs1_phys, 6'd41);
    chk("R11", "x5 restored to committed version", rs2_phys, 6'd37);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; iss_valid = 1'b0;
    rs1 = '0; rs2 = '0; rd = '0; rd_we = 1'b0;
    wb_valid = '0; wb_idx = '0; wb_data = '0; cm_ack = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    test_rename();
    test_youngest();
    test_commit();
    test_full();
    test_flush();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule